// File: doc/BRIEF.md
# Debounced Matrix Key Scanner

The block watches a keypad wired as a grid of drive lines and sense lines, six by five by default, thirty keys in all. While no key is down it holds the drive lines at fixed idle levels and does no scanning. When any sense line reads high it raises one drive line at a time, each for a fixed number of ticks, and records which sense lines respond. One pass over all drive lines is a scan. Each decision compares two back-to-back scans.

When the two scans agree and show at least one key, the block stores the key image and pulls an active-low request line toward the host. The host starts a transfer, which releases the request. When the host signals that the transfer is done, the block goes back to watching for a press. Timing is counted in ticks of an enable input that stands for one period of the slow oscillator. A sleep code picks which drive lines stay high while the block is idle, so only keys on those lines can wake it. A blanking input clears the image and holds the scanner idle.

Top module: `kscan_matrix`

## Requirements
- R1: After reset, `req_no` is 1, `keys_o` is 0, and `drive_o` shows the idle pattern for the current sleep code.
- R2: While idle, `drive_o` (bit 0 is drive line 1) depends on `sleep_code_i` as follows: 00 drives all lines high; 01 drives only line 6 high; 10 drives lines 5 and 6 high; 11 drives lines 2 to 6 high.
- R3: With no sense line high, the block stays idle, `drive_o` keeps the idle pattern and `req_no` stays 1.
- R4: A scan pair is REQ_TICKS ticks long and holds two scans of SCAN_TICKS ticks each. In each scan, drive lines 1 to 6 are raised one at a time in that order, each for SCAN_TICKS/6 ticks, with exactly one line high. For the rest of the pair, `drive_o` shows the idle pattern.
- R5: If both scans of a pair agree and are nonzero, `req_no` goes low after exactly REQ_TICKS ticks from the start of the scan. `keys_o` bit 5*(k-1)+(j-1) holds the key on drive line k and sense line j.
- R6: If the two scans differ and the second one is nonzero, a new pair starts at once. The request then comes 2*REQ_TICKS ticks after the first scan started, and it carries the key image of the later pair.
- R7: If the second scan of a pair is all zero, the block returns to idle without a request.
- R8: `xfer_start_i` high while the request is pending releases `req_no` on the next clock. `xfer_done_i` then sends the block to idle. A new scan starts at once if a key is still held, and none starts if the keys were released.
- R9: In sleep, a press on a drive line that idles low does not start a scan. A press on a line that idles high does start one, and that scan covers all lines. The sleep idle pattern returns after the read.
- R10: `blank_i` aborts any scan or request on the next clock, clears `keys_o`, keeps `req_no` at 1, and blocks scanning for as long as it is high.
- R11: The pair timer advances only on clocks where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One oscillator period elapsed |
| blank_i | input | 1 | Blanking reset, synchronous, active high |
| sleep_code_i | input | 2 | 00 normal, other values select a sleep idle pattern |
| sense_i | input | N_SNS | Raw sense lines from the key matrix |
| drive_o | output | N_DRV | Drive lines to the key matrix |
| xfer_start_i | input | 1 | Host transfer started |
| xfer_done_i | input | 1 | Host transfer finished |
| req_no | output | 1 | Key read request, active low |
| keys_o | output | N_DRV*N_SNS | Latched key image |

## Verification
Scan start is not counted from the press, because the sense path runs through a two-flop synchronizer and so has a latency of its own. Instead it is taken from the clock edge where `drive_o` first shows drive line 1 alone. From that edge the request is due exactly REQ_TICKS applied ticks later, or twice that after a mismatch. The bench samples on the falling edge, counts the ticks it applied, and compares the count once `req_no` first reads low. The request is released on the first clock after `xfer_start_i`. A blank takes effect on the first clock after `blank_i`. Key changes made mid-pair are timed to land between the last sample of the first scan and the first sample of the second.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_REQ  = 2'd2,
    ST_READ = 2'd3
  } kscan_state_e;
endpackage

// File: rtl/kscan_sync.sv
module kscan_sync #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
  parameter int N_DRV = 6,
  parameter int N_SNS = 5,
  localparam int N_KEYS = N_DRV * N_SNS,
  localparam int ROW_W  = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              second_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [N_SNS-1:0]  sense_i,
  output logic [N_KEYS-1:0] first_o,
  output logic [N_KEYS-1:0] second_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_o  <= '0;
      second_o <= '0;
    end else if (sample_i) begin
      for (int k = 0; k < N_DRV; k++) begin
        if (row_i == ROW_W'(k)) begin
          if (second_i) second_o[k*N_SNS +: N_SNS] <= sense_i;
          else          first_o[k*N_SNS +: N_SNS]  <= sense_i;
        end
      end
    end
  end

  assert_row_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> (row_i < ROW_W'(N_DRV)));
endmodule

// File: rtl/kscan_matrix.sv
module kscan_matrix
  import kscan_pkg::*;
#(
  parameter int N_DRV      = 6,
  parameter int N_SNS      = 5,
  parameter int SCAN_TICKS = 12000,
  parameter int REQ_TICKS  = 25600,
  localparam int N_KEYS    = N_DRV * N_SNS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              blank_i,
  input  logic [1:0]        sleep_code_i,
  input  logic [N_SNS-1:0]  sense_i,
  output logic [N_DRV-1:0]  drive_o,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic              req_no,
  output logic [N_KEYS-1:0] keys_o
);
  localparam int ROW_TICKS = SCAN_TICKS / N_DRV;
  localparam int CNT_W     = $clog2(REQ_TICKS);
  localparam int SLOT_W    = (ROW_TICKS > 1) ? $clog2(ROW_TICKS) : 1;
  localparam int ROW_W     = (N_DRV > 1) ? $clog2(N_DRV) : 1;

  kscan_state_e       state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [ROW_W-1:0]   row_q;
  logic [N_SNS-1:0]   sense_s;
  logic [N_KEYS-1:0]  scan_a, scan_b;
  logic               in_win, in_second, sample, pair_end, press;

  function automatic logic [N_DRV-1:0] idle_pattern(input logic [1:0] code);
    logic [N_DRV-1:0] p;
    for (int k = 0; k < N_DRV; k++) begin
      case (code)
        2'b00:   p[k] = 1'b1;
        2'b01:   p[k] = (k == N_DRV-1);
        2'b10:   p[k] = (k >= N_DRV-2);
        default: p[k] = (k >= 1);
      endcase
    end
    return p;
  endfunction

  kscan_sync #(.WIDTH(N_SNS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sense_i),
    .q_o   (sense_s)
  );

  assign in_win    = cnt_q < CNT_W'(2*SCAN_TICKS);
  assign in_second = cnt_q >= CNT_W'(SCAN_TICKS);
  assign press     = |sense_s;
  assign pair_end  = (state_q == ST_SCAN) && tick_i && (cnt_q == CNT_W'(REQ_TICKS-1));
  assign sample    = (state_q == ST_SCAN) && tick_i && in_win && !blank_i &&
                     (slot_q == SLOT_W'(ROW_TICKS-1));

  kscan_capture #(.N_DRV(N_DRV), .N_SNS(N_SNS)) i_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sample_i(sample),
    .second_i(in_second),
    .row_i   (row_q),
    .sense_i (sense_s),
    .first_o (scan_a),
    .second_o(scan_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      row_q   <= '0;
      keys_o  <= '0;
    end else if (blank_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
      row_q   <= '0;
      keys_o  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (press) begin
          state_q <= ST_SCAN;
          cnt_q   <= '0;
          slot_q  <= '0;
          row_q   <= '0;
        end
        ST_SCAN: if (tick_i) begin
          if (pair_end) begin
            cnt_q  <= '0;
            slot_q <= '0;
            row_q  <= '0;
            if (scan_b == '0) begin
              state_q <= ST_IDLE;
            end else if (scan_a == scan_b) begin
              keys_o  <= scan_b;
              state_q <= ST_REQ;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (in_win) begin
              if (slot_q == SLOT_W'(ROW_TICKS-1)) begin
                slot_q <= '0;
                row_q  <= (row_q == ROW_W'(N_DRV-1)) ? '0 : row_q + ROW_W'(1);
              end else begin
                slot_q <= slot_q + SLOT_W'(1);
              end
            end
          end
        end
        ST_REQ:  if (xfer_start_i) state_q <= ST_READ;
        ST_READ: if (xfer_done_i)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign drive_o = (state_q == ST_SCAN && in_win) ? (N_DRV'(1) << row_q)
                                                  : idle_pattern(sleep_code_i);
  assign req_no  = (state_q != ST_REQ);

  assert_req_has_keys_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_no |-> (keys_o != '0));
  assert_req_from_pair_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_no) |-> ($past(state_q) == ST_SCAN && $past(tick_i)));
  assert_start_releases_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_no && xfer_start_i && !blank_i) |=> req_no);
  assert_blank_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (req_no && keys_o == '0));
  assert_timer_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && !tick_i && !blank_i) |=> $stable(cnt_q));
endmodule

// File: tb/test_kscan_matrix.sv
module test_kscan_matrix;
  localparam int SCAN = 24;
  localparam int REQ  = 52;
  localparam int ROW  = SCAN / 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b1;
  logic        blank = 1'b0;
  logic [1:0]  code = 2'b00;
  logic [4:0]  sense;
  logic [5:0]  drive;
  logic        xs = 1'b0, xd = 1'b0;
  logic        req_no;
  logic [29:0] keys_o;
  logic [29:0] key_mat = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kscan_matrix #(.N_DRV(6), .N_SNS(5), .SCAN_TICKS(SCAN), .REQ_TICKS(REQ)) i_kscan_matrix (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .blank_i(blank),
    .sleep_code_i(code), .sense_i(sense), .drive_o(drive),
    .xfer_start_i(xs), .xfer_done_i(xd), .req_no(req_no), .keys_o(keys_o));

  always_comb begin
    sense = '0;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 5; j++)
        if (drive[k] && key_mat[k*5+j]) sense[j] = 1'b1;
  end

  function automatic logic [5:0] idle_of(input logic [1:0] c);
    case (c)
      2'b00:   return 6'b111111;
      2'b01:   return 6'b100000;
      2'b10:   return 6'b110000;
      default: return 6'b111110;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_start(output bit found);
    found = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (drive == 6'b000001) begin found = 1'b1; break; end
    end
  endtask

  task automatic run_scan(input bit rnd, input int chg_at, input logic [29:0] chg,
                          input logic [5:0] idle_exp, output int ticks, output bit got,
                          output logic [5:0] drv_at_req, output bit order_ok);
    logic [5:0] exp_d;
    ticks = 0; got = 1'b0; drv_at_req = '0; order_ok = 1'b1;
    for (int i = 0; i < 3*REQ+10; i++) begin
      if (!req_no) begin got = 1'b1; break; end
      if (!rnd && i < REQ) begin
        exp_d = (i < 2*SCAN) ? (6'b000001 << ((i % SCAN) / ROW)) : idle_exp;
        if (drive != exp_d) order_ok = 1'b0;
      end
      if (i == REQ) drv_at_req = drive;
      if (i == chg_at) key_mat = chg;
      tick = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
      ticks += int'(tick);
      @(negedge clk);
    end
    tick = 1'b1;
  endtask

  task automatic do_read(input bit release_keys);
    xs = 1'b1;
    if (release_keys) key_mat = '0;
    @(negedge clk);
    check(req_no == 1'b1, "R8 release on start", req_no, 1);
    xs = 1'b0;
    repeat (3) @(negedge clk);
    xd = 1'b1;
    @(negedge clk);
    xd = 1'b0;
  endtask

  initial begin
    bit found, got, ok_order;
    int ticks;
    logic [5:0] dmid;
    logic [29:0] ka, kb;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    check(req_no == 1'b1, "R1 req after reset", req_no, 1);
    check(keys_o == '0, "R1 keys after reset", keys_o, 0);
    check(drive == 6'b111111, "R1 idle drive after reset", drive, 6'b111111);
    rst_ni = 1'b1;

    // R3: no press, nothing moves
    found = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (drive != 6'b111111 || !req_no) found = 1'b0;
    end
    check(found, "R3 idle without press", drive, 6'b111111);

    // R4/R5 directed: single key row1 sense1
    key_mat = 30'h1;
    wait_start(found);
    check(found, "R5 scan started", drive, 1);
    run_scan(1'b0, -1, '0, 6'b111111, ticks, got, dmid, ok_order);
    check(ok_order, "R4 drive order", 0, 1);
    check(got && ticks == REQ, "R5 request timing", ticks, REQ);
    check(keys_o == 30'h1, "R5 key image", keys_o, 30'h1);

    // R8: held key restarts scan
    do_read(1'b0);
    wait_start(found);
    check(found, "R8 rescan with key held", drive, 1);
    run_scan(1'b0, -1, '0, 6'b111111, ticks, got, dmid, ok_order);
    check(got && ticks == REQ, "R8 second request", ticks, REQ);
    do_read(1'b1);
    found = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (drive != 6'b111111 || !req_no) found = 1'b0;
    end
    check(found, "R8 idle after release", drive, 6'b111111);

    // R5/R11: random keys and random ticks
    for (int n = 0; n < 6; n++) begin
      ka = 30'($urandom());
      if (ka == '0) ka = 30'h20;
      key_mat = ka;
      wait_start(found);
      run_scan(1'b1, -1, '0, 6'b111111, ticks, got, dmid, ok_order);
      check(got && ticks == REQ, "R11 tick-gated timing", ticks, REQ);
      check(keys_o == ka, "R5 random key image", keys_o, ka);
      do_read(1'b1);
      repeat (4) @(negedge clk);
    end

    // R6: mismatch between scans
    ka = 30'h0000_0421;
    kb = 30'h2000_0002;
    key_mat = ka;
    wait_start(found);
    run_scan(1'b0, SCAN+1, kb, 6'b111111, ticks, got, dmid, ok_order);
    check(got && ticks == 2*REQ, "R6 retry timing", ticks, 2*REQ);
    check(keys_o == kb, "R6 later image", keys_o, kb);
    do_read(1'b1);
    repeat (4) @(negedge clk);

    // R7: release before second scan
    key_mat = 30'h0001_0000;
    wait_start(found);
    run_scan(1'b0, SCAN+1, '0, 6'b111111, ticks, got, dmid, ok_order);
    check(!got, "R7 no request", req_no, 1);
    check(dmid == 6'b111111, "R7 back to idle", dmid, 6'b111111);

    // R2: sleep idle patterns
    for (int c = 1; c < 4; c++) begin
      code = 2'(c);
      @(negedge clk);
      check(drive == idle_of(code), "R2 sleep idle pattern", drive, idle_of(code));
    end

    // R9: wake only from high idle lines
    code = 2'b01;
    key_mat = 30'h1;
    found = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (drive != 6'b100000 || !req_no) found = 1'b0;
    end
    check(found, "R9 low line press ignored", drive, 6'b100000);
    key_mat = 30'h0200_0001;
    wait_start(found);
    check(found, "R9 wake from line 6", drive, 1);
    run_scan(1'b0, -1, '0, 6'b100000, ticks, got, dmid, ok_order);
    check(got && ticks == REQ, "R9 request in sleep", ticks, REQ);
    check(keys_o == 30'h0200_0001, "R9 full image in sleep", keys_o, 30'h0200_0001);
    do_read(1'b1);
    @(negedge clk);
    check(drive == 6'b100000, "R9 sleep pattern kept", drive, 6'b100000);
    code = 2'b00;
    repeat (4) @(negedge clk);

    // R10: blank aborts scan
    key_mat = 30'h0000_8000;
    wait_start(found);
    repeat (10) @(negedge clk);
    blank = 1'b1;
    @(negedge clk);
    check(drive == 6'b111111, "R10 drive idle on blank", drive, 6'b111111);
    check(req_no == 1'b1 && keys_o == '0, "R10 image cleared", keys_o, 0);
    found = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (drive != 6'b111111 || !req_no) found = 1'b0;
    end
    check(found, "R10 no scan while blank", drive, 6'b111111);
    key_mat = '0;
    repeat (3) @(negedge clk);
    blank = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule